// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Hardware Refill

This block turns 16-bit virtual addresses into 16-bit physical addresses. It sits between a requester and memory and holds a small fully associative set of recent page-to-frame mappings. Each stored mapping carries the owning address-space identifier, so mappings from several processes can sit side by side without any flush when the current process changes. All stored mappings are compared in the same cycle. A hit returns the translated address on the next cycle and makes no memory access.

When no stored mapping matches, the block fetches one 16-bit page-table entry through a one-shot memory read request and waits for the data. It then installs the mapping and answers the original request from it. An invalid or malformed entry gives a page fault, and a write to a read-only page gives a permission fault. The block handles one request at a time. A single flush pulse invalidates every stored mapping.

Top module: `xlat_buffer`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, all response flags are 0, and no stored mapping is valid.
- R2: The virtual address splits into page number bits 15:8 and offset bits 7:0. On a hit the response comes one cycle after the request is accepted, with `rsp_hit`=1 and `rsp_paddr` = {stored frame, offset}, and there is no memory read.
- R3: A stored mapping hits only when it is valid, its page number equals the requested page and its identifier equals `req_asid`. The same page held under two identifiers keeps two independent mappings.
- R4: On a miss the block raises `mem_rd_valid` for exactly one cycle with `mem_rd_addr` = `pt_base` + 2 × page number. The page-table entry format is: bit 15 valid, bit 14 write allowed, bits 13:8 reserved (must be zero), bits 7:0 frame. The response comes in the cycle after `mem_rsp_valid`, with `rsp_hit`=0, and the mapping is then installed, so a repeat of the request hits.
- R5: Only one request is in flight. `req_ready` stays 0 from the accepted miss until its response has been given.
- R6: A fetched entry with bit 15 clear or any reserved bit set gives `rsp_pgfault`=1, `rsp_hit`=0 and `rsp_paddr`=0, and nothing is installed, so a repeat of the request misses again.
- R7: A write to a page without write permission gives `rsp_permfault`=1 and `rsp_paddr`=0, whether the mapping was found stored (`rsp_hit`=1) or fetched (`rsp_hit`=0).
- R8: A permitted write marks the mapping dirty. `rsp_dirty` reports the dirty state of the mapping after the access, both on the write itself and on later hits.
- R9: A refill fills the lowest-numbered invalid slot first. When every slot is valid, it evicts the slot named by a rotating pointer. The pointer starts at slot 0 and moves one slot on after each eviction, so mappings leave in first-in, first-out order.
- R10: A one-cycle `flush` pulse invalidates every stored mapping, so the next access to any page misses.
- R11: With page 0x12 mapped to frame 0x09, virtual address 0x1234 translates to 0x0934.
- R12: All response flags are 0 whenever `rsp_valid` is 0, and the two fault flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all stored mappings |
| pt_base | input | 16 | Byte base address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_asid | input | 4 | Address-space identifier of the requester |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| rsp_hit | output | 1 | Mapping was already stored |
| rsp_dirty | output | 1 | Mapping is marked dirty |
| rsp_pgfault | output | 1 | Page-table entry unusable |
| rsp_permfault | output | 1 | Write to a read-only page |
| mem_rd_valid | output | 1 | Page-table read request (one cycle) |
| mem_rd_addr | output | 16 | Byte address of the page-table entry |
| mem_rsp_valid | input | 1 | Page-table read data present |
| mem_rsp_data | input | 16 | Page-table entry |

## Verification
The stimulus repeats the same page under two identifiers, which separates a true hit from a plain page-number match. It sends reads and writes to pages with and without write permission, and it puts invalid and malformed table entries next to good ones, so the fault flags, the dirty flag and the install rule each give a different result. After the store is full, a sequence of misses and probes shows which slot was evicted: a probe that hits cannot be told apart from a refill except by the hit flag and the memory-read count, and both are checked. A flush followed by a probe of a page that hit before shows that the store was cleared.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W      = 16;
    localparam int OFF_W     = 8;
    localparam int PAGE_W    = VA_W - OFF_W;
    localparam int FRAME_W   = 8;
    localparam int ASID_W    = 4;
    localparam int SLOTS     = 8;
    localparam int PTE_W     = 16;
    localparam int PTE_V_BIT = 15;
    localparam int PTE_W_BIT = 14;
    localparam int RSV_HI    = 13;
    localparam int RSV_LO    = FRAME_W;

    typedef struct packed {
        logic                valid;
        logic                dirty;
        logic                wr_ok;
        logic [ASID_W-1:0]   asid;
        logic [PAGE_W-1:0]   vpn;
        logic [FRAME_W-1:0]  pfn;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_e;

    // Entry is usable when marked valid and the reserved field is clear.
    function automatic logic pte_usable(input logic [PTE_W-1:0] p);
        return p[PTE_V_BIT] && (p[RSV_HI:RSV_LO] == '0);
    endfunction

    // Each table entry occupies two bytes.
    function automatic logic [VA_W-1:0] pte_byte_addr(input logic [VA_W-1:0] base,
                                                      input logic [PAGE_W-1:0] vpn);
        return base + VA_W'({vpn, 1'b0});
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = SLOTS
) (
    input  slot_t [N-1:0]          tbl,
    input  logic  [PAGE_W-1:0]     vpn,
    input  logic  [ASID_W-1:0]     asid,
    output logic                   hit,
    output slot_t                  ent
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] match;
    logic [IW-1:0] idx;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = tbl[g].valid && (tbl[g].vpn == vpn) && (tbl[g].asid == asid);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IW'(i);
        end
        ent = tbl[idx];
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int N = SLOTS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N-1:0]                 valid_vec,
    input  logic                         take,
    output logic [((N>1)?$clog2(N):1)-1:0] idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          free;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] ptr;

    always_comb begin
        free     = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free     = 1'b1;
                free_idx = IW'(i);
            end
        end
        idx = free ? free_idx : ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take && !free) begin
            ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N = SLOTS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           ins_en,
    input  logic [((N>1)?$clog2(N):1)-1:0] ins_idx,
    input  slot_t                          ins_ent,
    input  logic                           mark_en,
    input  logic [PAGE_W-1:0]              mark_vpn,
    input  logic [ASID_W-1:0]              mark_asid,
    output slot_t [N-1:0]                  tbl,
    output logic  [N-1:0]                  valid_vec
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ins_en && (ins_idx == IW'(i))) begin
                    tbl[i] <= ins_ent;
                end else if (mark_en && tbl[i].valid && (tbl[i].vpn == mark_vpn)
                             && (tbl[i].asid == mark_asid)) begin
                    tbl[i].dirty <= 1'b1;
                end
                if (flush) tbl[i].valid <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_vld
        assign valid_vec[g] = tbl[g].valid;
    end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = SLOTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VA_W-1:0]    pt_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic [ASID_W-1:0]  req_asid,
    output logic               rsp_valid,
    output logic [VA_W-1:0]    rsp_paddr,
    output logic               rsp_hit,
    output logic               rsp_dirty,
    output logic               rsp_pgfault,
    output logic               rsp_permfault,
    output logic               mem_rd_valid,
    output logic [VA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    walk_e               st;
    logic [PAGE_W-1:0]   cur_vpn;
    logic [OFF_W-1:0]    cur_off;
    logic                cur_wr;
    logic [ASID_W-1:0]   cur_asid;

    slot_t [ENTRIES-1:0] tbl;
    logic  [ENTRIES-1:0] valid_vec;
    logic                lk_hit;
    slot_t               lk_ent;
    logic [IW-1:0]       vic_idx;

    logic [PAGE_W-1:0]   req_vpn;
    logic [OFF_W-1:0]    req_off;
    logic                accept;
    logic                pte_ok;
    logic                pte_wr;
    logic                ins_en;
    logic                mark_en;
    slot_t               ins_ent;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    assign pte_ok  = pte_usable(mem_rsp_data);
    assign pte_wr  = mem_rsp_data[PTE_W_BIT];
    assign ins_en  = (st == ST_WAIT) && mem_rsp_valid && pte_ok;
    assign mark_en = accept && lk_hit && req_write && lk_ent.wr_ok;

    always_comb begin
        ins_ent       = '0;
        ins_ent.valid = 1'b1;
        ins_ent.dirty = cur_wr && pte_wr;
        ins_ent.wr_ok = pte_wr;
        ins_ent.asid  = cur_asid;
        ins_ent.vpn   = cur_vpn;
        ins_ent.pfn   = mem_rsp_data[FRAME_W-1:0];
    end

    assign mem_rd_valid = (st == ST_ISSUE);
    assign mem_rd_addr  = pte_byte_addr(pt_base, cur_vpn);

    xlat_match #(.N(ENTRIES)) u_match (
        .tbl  (tbl),
        .vpn  (req_vpn),
        .asid (req_asid),
        .hit  (lk_hit),
        .ent  (lk_ent)
    );

    xlat_victim #(.N(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .take      (ins_en),
        .idx       (vic_idx)
    );

    xlat_store #(.N(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .ins_en    (ins_en),
        .ins_idx   (vic_idx),
        .ins_ent   (ins_ent),
        .mark_en   (mark_en),
        .mark_vpn  (req_vpn),
        .mark_asid (req_asid),
        .tbl       (tbl),
        .valid_vec (valid_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            cur_vpn       <= '0;
            cur_off       <= '0;
            cur_wr        <= 1'b0;
            cur_asid      <= '0;
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_hit       <= 1'b0;
            rsp_dirty     <= 1'b0;
            rsp_pgfault   <= 1'b0;
            rsp_permfault <= 1'b0;
        end else begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_hit       <= 1'b0;
            rsp_dirty     <= 1'b0;
            rsp_pgfault   <= 1'b0;
            rsp_permfault <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            if (req_write && !lk_ent.wr_ok) begin
                                rsp_permfault <= 1'b1;
                                rsp_dirty     <= lk_ent.dirty;
                            end else begin
                                rsp_paddr <= {lk_ent.pfn, req_off};
                                rsp_dirty <= lk_ent.dirty || req_write;
                            end
                        end else begin
                            cur_vpn  <= req_vpn;
                            cur_off  <= req_off;
                            cur_wr   <= req_write;
                            cur_asid <= req_asid;
                            st       <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        st        <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        if (!pte_ok) begin
                            rsp_pgfault <= 1'b1;
                        end else if (cur_wr && !pte_wr) begin
                            rsp_permfault <= 1'b1;
                        end else begin
                            rsp_paddr <= {mem_rsp_data[FRAME_W-1:0], cur_off};
                            rsp_dirty <= cur_wr;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk
    import xlat_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [VA_W-1:0] rsp_paddr,
    input logic            rsp_hit,
    input logic            rsp_dirty,
    input logic            rsp_pgfault,
    input logic            rsp_permfault,
    input logic            mem_rd_valid
);
    // R5
    busy_during_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !req_ready);

    // R4
    single_fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);

    // R2
    hit_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

    // R5
    refill_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> !$past(req_ready));

    // R12
    quiet_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_dirty || rsp_pgfault || rsp_permfault));

    // R12
    fault_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_pgfault && rsp_permfault));

    // R6
    pgfault_shape_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_pgfault |-> (!rsp_hit && rsp_paddr == '0));

    // R7
    permfault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_permfault |-> (rsp_paddr == '0));

endmodule

bind xlat_buffer xlat_buffer_chk u_chk (.*);

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic [15:0] pt_base;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_vaddr;
    logic        req_write;
    logic [3:0]  req_asid;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_hit;
    logic        rsp_dirty;
    logic        rsp_pgfault;
    logic        rsp_permfault;
    logic        mem_rd_valid;
    logic [15:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_data;

    int total = 0;
    int bad   = 0;
    int mem_reads = 0;

    always #2 clk = ~clk;

    xlat_buffer dut (.*);

    // Page-table model: frame = page ^ 0x1B ^ (base[15:8] - 0x10);
    // page 0xEE is invalid, page 0xED has a reserved bit set, odd pages are read-only.
    function automatic logic [7:0] frame_of(input logic [7:0] vpn, input logic [15:0] base);
        return vpn ^ 8'h1B ^ (base[15:8] - 8'h10);
    endfunction

    function automatic logic [15:0] pte_of(input logic [15:0] addr, input logic [15:0] base);
        logic [7:0] vpn;
        vpn = 8'((addr - base) >> 1);
        return {(vpn != 8'hEE), ~vpn[0], ((vpn == 8'hED) ? 6'h01 : 6'h00), frame_of(vpn, base)};
    endfunction

    logic [15:0] pend_addr;
    int          pend_cnt = 0;
    always @(posedge clk) begin
        if (mem_rd_valid) begin
            mem_reads <= mem_reads + 1;
            pend_addr <= mem_rd_addr;
            pend_cnt  <= 3;
        end else if (pend_cnt > 0) begin
            pend_cnt <= pend_cnt - 1;
        end
    end
    assign mem_rsp_valid = (pend_cnt == 1);
    assign mem_rsp_data  = pte_of(pend_addr, pt_base);

    typedef struct packed {
        logic [15:0] va;
        logic        wr;
        logic [3:0]  asid;
        logic [15:0] base;
        logic        hit;
        logic        pf;
        logic        perm;
        logic        dirty;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{16'h1234, 1'b0, 4'd1, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h1234, 1'b0, 4'd1, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'h1234, 1'b0, 4'd2, 16'h3000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h1234, 1'b0, 4'd1, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'h13FF, 1'b1, 4'd1, 16'h1000, 1'b0, 1'b0, 1'b1, 1'b0},
        '{16'h1300, 1'b1, 4'd1, 16'h1000, 1'b1, 1'b0, 1'b1, 1'b0},
        '{16'h1300, 1'b0, 4'd1, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'hEE10, 1'b0, 4'd1, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0},
        '{16'hEE10, 1'b0, 4'd1, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0},
        '{16'h2480, 1'b1, 4'd1, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b1},
        '{16'h2480, 1'b0, 4'd1, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b1},
        '{16'hED01, 1'b0, 4'd1, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v, input string tag);
        int          lat;
        int          r0;
        logic        busy_seen_ready;
        logic [15:0] exp_pa;
        @(negedge clk);
        pt_base   = v.base;
        req_vaddr = v.va;
        req_write = v.wr;
        req_asid  = v.asid;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        r0 = mem_reads;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_seen_ready = 1'b0;
        while (!rsp_valid && lat < 100) begin
            if (req_ready) busy_seen_ready = 1'b1;
            @(negedge clk);
            lat++;
        end
        exp_pa = (v.pf || v.perm) ? 16'h0 : {frame_of(v.va[15:8], v.base), v.va[7:0]};
        chk(rsp_valid, {tag, " R4 response arrives"}, 32'(rsp_valid), 32'd1);
        chk(rsp_hit == v.hit, {tag, " R3 hit flag"}, 32'(rsp_hit), 32'(v.hit));
        chk(rsp_paddr == exp_pa, {tag, " R2 physical address"}, 32'(rsp_paddr), 32'(exp_pa));
        chk(rsp_pgfault == v.pf, {tag, " R6 page fault"}, 32'(rsp_pgfault), 32'(v.pf));
        chk(rsp_permfault == v.perm, {tag, " R7 permission fault"}, 32'(rsp_permfault), 32'(v.perm));
        chk(rsp_dirty == v.dirty, {tag, " R8 dirty flag"}, 32'(rsp_dirty), 32'(v.dirty));
        chk((mem_reads - r0) == (v.hit ? 0 : 1), {tag, " R4 memory reads"},
            32'(mem_reads - r0), v.hit ? 32'd0 : 32'd1);
        if (v.hit) chk(lat == 1, {tag, " R2 hit latency"}, 32'(lat), 32'd1);
        else       chk(!busy_seen_ready, {tag, " R5 ready low during refill"},
                       32'(busy_seen_ready), 32'd0);
        @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !rsp_pgfault && !rsp_permfault,
            {tag, " R12 flags quiet after response"}, 32'(rsp_valid), 32'd0);
    endtask

    function automatic vec_t mk(input logic [15:0] va, input logic [3:0] asid,
                                input logic hit);
        vec_t v;
        v.va = va; v.wr = 1'b0; v.asid = asid;
        v.base = (asid == 4'd2) ? 16'h3000 : 16'h1000;
        v.hit = hit; v.pf = 1'b0; v.perm = 1'b0; v.dirty = 1'b0;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R5 watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; pt_base = 16'h1000;
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_asid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(!rsp_valid && !rsp_hit && !rsp_dirty && !rsp_pgfault && !rsp_permfault,
            "R1 response idle after reset", 32'(rsp_valid), 32'd0);
        chk(!mem_rd_valid, "R1 no memory read after reset", 32'(mem_rd_valid), 32'd0);

        // R11 example first (row 0), R3 two identifiers, R7 both paths, R6, R8
        for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d", i));

        // R9: slots 0..3 hold (12,1) (12,2) (13,1) (24,1); fill 4..7
        for (int k = 0; k < 4; k++) run(mk(16'h4000 + 16'(k << 8), 4'd1, 1'b0), "R9 fill");
        run(mk(16'h5011, 4'd1, 1'b0), "R9 evict slot0");
        run(mk(16'h1234, 4'd2, 1'b1), "R9 slot1 kept");
        run(mk(16'h1234, 4'd1, 1'b0), "R9 oldest gone, evict slot1");
        run(mk(16'h1300, 4'd1, 1'b1), "R9 slot2 kept");
        run(mk(16'h1234, 4'd2, 1'b0), "R9 second oldest gone");
        run(mk(16'h1300, 4'd1, 1'b0), "R9 third oldest gone");
        run(mk(16'h4000, 4'd1, 1'b1), "R9 young entry kept");

        // R10 flush clears everything
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        run(mk(16'h4000, 4'd1, 1'b0), "R10 miss after flush");
        run(mk(16'h1234, 4'd1, 1'b0), "R10 R11 refetch after flush");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule